// File: doc/BRIEF.md
# Machine Trap Status Stack

This unit holds the privilege state of a single RV32 hart at machine level. It keeps the current privilege mode, the machine status word and the exception return address. It also implements the two-deep stack that saves the privilege mode and the machine interrupt enable when a trap is taken, and restores them when the return-from-trap instruction retires.

The pipeline drives the unit with single-cycle strobes. A trap strobe comes with the PC of the faulting instruction. A return strobe marks an MRET. A CSR write port targets either the status word or the return address. The unit produces the current privilege and a redirect address that is valid in the same cycle as a legal return. It also flags an MRET issued below machine mode as an illegal instruction, and returns the read values of both registers.

Firmware can use the same path to enter a lower mode deliberately. It writes the previous-privilege and previous-enable fields with a CSR write, then issues MRET to drop into that mode.

Top module: `trap_status_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, priv_o reads 2'b11 (machine), mstatus_o reads zero and mepc_o reads zero. Privilege encodings: user 2'b00, supervisor 2'b01, machine 2'b11.
- R2: A trap strobe takes effect at the next rising edge. mepc takes trap_pc_i with bits 1:0 cleared. MPP takes the current privilege, MPIE takes the current MIE, MIE clears and the privilege becomes machine.
- R3: An MRET strobe in machine mode raises redirect_valid_o in the same cycle, with redirect_pc_o equal to mepc_o. At the next edge the privilege takes the old MPP and MIE takes the old MPIE.
- R4: After a legal MRET, MPP reads user (2'b00) and MPIE reads 1.
- R5: An MRET strobe below machine mode raises illegal_o in that cycle and keeps redirect_valid_o low. Privilege, mstatus_o and mepc_o remain unchanged across the following edge.
- R6: mstatus bit positions are UIE 0, SIE 1, MIE 3, UPIE 4, SPIE 5, MPIE 7, SPP 8 and MPP 12:11. A CSR write with csr_sel_i=0 loads all of these fields.
- R7: mstatus bits 2, 6, 10:9 and 31:13 always read zero, and writes to them are ignored.
- R8: A write of 2'b10 to MPP stores user (2'b00).
- R9: A trap strobe beats a concurrent MRET strobe, and in that case neither illegal_o nor redirect_valid_o is raised. A CSR write is dropped in any cycle that carries a trap or MRET strobe.
- R10: mepc_o bits 1:0 always read zero. A CSR write with csr_sel_i=1 stores csr_wdata_i with those bits cleared.
- R11: Writing MPP=supervisor with MPIE=0 and then issuing MRET leaves the hart in supervisor mode with MIE cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Trap entry strobe |
| trap_pc_i | input | 32 | PC of the trapping instruction |
| mret_i | input | 1 | Return-from-trap strobe |
| csr_we_i | input | 1 | CSR write enable |
| csr_sel_i | input | 1 | CSR write target: 0 status word, 1 return address |
| csr_wdata_i | input | 32 | CSR write data |
| priv_o | output | 2 | Current privilege mode |
| redirect_valid_o | output | 1 | Legal MRET this cycle; fetch from redirect_pc_o |
| redirect_pc_o | output | 32 | Return target (current mepc) |
| illegal_o | output | 1 | MRET issued below machine mode |
| mstatus_o | output | 32 | Status word read value |
| mepc_o | output | 32 | Return address read value |

## Verification
The bench walks a sequence of operations in which each step depends on state left by the previous one. A design that swapped the save or restore direction of the stack would end up in the wrong privilege within two steps. Concurrent trap and MRET strobes are checked so that a design giving MRET priority shows a redirect and loses the saved PC. An MRET issued from supervisor mode together with a CSR write is checked: a design that applies either would change mstatus_o. Writes of the reserved MPP code and of reserved status bits are read back, so a design that stores them shows a nonzero value where zero is expected. Low return-address bits are written as ones, so a design that keeps them shows an unaligned mepc_o.

// File: rtl/trap_status_pkg.sv
package trap_status_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  localparam int unsigned BIT_UIE  = 0;
  localparam int unsigned BIT_SIE  = 1;
  localparam int unsigned BIT_MIE  = 3;
  localparam int unsigned BIT_UPIE = 4;
  localparam int unsigned BIT_SPIE = 5;
  localparam int unsigned BIT_MPIE = 7;
  localparam int unsigned BIT_SPP  = 8;
  localparam int unsigned BIT_MPP  = 11;
  localparam int unsigned STAT_TOP = BIT_MPP + 1;

  typedef struct packed {
    logic  uie;
    logic  sie;
    logic  mie;
    logic  upie;
    logic  spie;
    logic  mpie;
    logic  spp;
    priv_e mpp;
  } stat_t;

  function automatic priv_e legal_mpp(input logic [1:0] v);
    return (v == 2'b10) ? PRIV_U : priv_e'(v);
  endfunction

endpackage

// File: rtl/tsu_event_arb.sv
module tsu_event_arb
  import trap_status_pkg::*;
(
  input  logic  rst_ni,
  input  logic  clk_i,
  input  logic  trap_i,
  input  logic  mret_i,
  input  logic  csr_we_i,
  input  logic  csr_sel_i,
  input  priv_e priv_i,
  output logic  do_trap_o,
  output logic  do_mret_o,
  output logic  illegal_o,
  output logic  wr_stat_o,
  output logic  wr_epc_o
);

  logic strobe;
  logic mret_live;

  assign strobe    = trap_i | mret_i;
  assign mret_live = mret_i & ~trap_i;

  always_comb begin
    do_trap_o = trap_i;
    do_mret_o = mret_live & (priv_i == PRIV_M);
    illegal_o = mret_live & (priv_i != PRIV_M);
    wr_stat_o = csr_we_i & ~strobe & ~csr_sel_i;
    wr_epc_o  = csr_we_i & ~strobe &  csr_sel_i;
  end

  // R9: trap suppresses return handling
  a_r9_trap_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |-> (!do_mret_o && !illegal_o));

  // R9: no CSR write alongside a strobe
  a_r9_csr_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i || mret_i) |-> (!wr_stat_o && !wr_epc_o));

endmodule

// File: rtl/tsu_status_regs.sv
module tsu_status_regs
  import trap_status_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            do_trap_i,
  input  logic            do_mret_i,
  input  logic            wr_stat_i,
  input  logic [XLEN-1:0] wdata_i,
  output priv_e           priv_o,
  output logic [XLEN-1:0] mstatus_o
);

  priv_e priv_q, priv_d;
  stat_t st_q, st_d, st_w;

  // unused bits of the write word
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[XLEN-1:STAT_TOP+1], wdata_i[BIT_MPP-1:BIT_SPP+1],
                          wdata_i[BIT_MPIE-1], wdata_i[BIT_MIE-1]};

  always_comb begin
    st_w      = '0;
    st_w.uie  = wdata_i[BIT_UIE];
    st_w.sie  = wdata_i[BIT_SIE];
    st_w.mie  = wdata_i[BIT_MIE];
    st_w.upie = wdata_i[BIT_UPIE];
    st_w.spie = wdata_i[BIT_SPIE];
    st_w.mpie = wdata_i[BIT_MPIE];
    st_w.spp  = wdata_i[BIT_SPP];
    st_w.mpp  = legal_mpp(wdata_i[BIT_MPP +: 2]);
  end

  always_comb begin
    st_d   = st_q;
    priv_d = priv_q;
    if (do_trap_i) begin
      st_d.mpp  = priv_q;
      st_d.mpie = st_q.mie;
      st_d.mie  = 1'b0;
      priv_d    = PRIV_M;
    end else if (do_mret_i) begin
      priv_d    = st_q.mpp;
      st_d.mie  = st_q.mpie;
      st_d.mpie = 1'b1;
      st_d.mpp  = PRIV_U;
    end else if (wr_stat_i) begin
      st_d = st_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= PRIV_M;
      st_q   <= '0;
    end else begin
      priv_q <= priv_d;
      st_q   <= st_d;
    end
  end

  always_comb begin
    mstatus_o                = '0;
    mstatus_o[BIT_UIE]       = st_q.uie;
    mstatus_o[BIT_SIE]       = st_q.sie;
    mstatus_o[BIT_MIE]       = st_q.mie;
    mstatus_o[BIT_UPIE]      = st_q.upie;
    mstatus_o[BIT_SPIE]      = st_q.spie;
    mstatus_o[BIT_MPIE]      = st_q.mpie;
    mstatus_o[BIT_SPP]       = st_q.spp;
    mstatus_o[BIT_MPP +: 2]  = st_q.mpp;
  end

  assign priv_o = priv_q;

  // R2: trap lands in machine mode with MIE off
  a_r2_trap_to_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_trap_i |=> (priv_q == PRIV_M && !st_q.mie));

  // R2: previous privilege and enable saved
  a_r2_stack_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_trap_i |=> (st_q.mpp == $past(priv_q) && st_q.mpie == $past(st_q.mie)));

  // R3: privilege and MIE restored
  a_r3_stack_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_mret_i |=> (priv_q == $past(st_q.mpp) && st_q.mie == $past(st_q.mpie)));

  // R4: stack bottom refilled
  a_r4_stack_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_mret_i |=> (st_q.mpp == PRIV_U && st_q.mpie));

  // R8: MPP never holds the reserved code
  a_r8_mpp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.mpp != PRIV_RSVD);

endmodule

// File: rtl/tsu_epc_reg.sv
module tsu_epc_reg #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            do_trap_i,
  input  logic            wr_epc_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] mepc_o
);

  localparam int unsigned HI = XLEN - ALIGN_BITS;

  logic [HI-1:0] epc_q;

  logic unused_low;
  assign unused_low = ^{trap_pc_i[ALIGN_BITS-1:0], wdata_i[ALIGN_BITS-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        epc_q <= '0;
    else if (do_trap_i) epc_q <= trap_pc_i[XLEN-1:ALIGN_BITS];
    else if (wr_epc_i)  epc_q <= wdata_i[XLEN-1:ALIGN_BITS];
  end

  assign mepc_o = {epc_q, {ALIGN_BITS{1'b0}}};

  // R2: trap captures the aligned faulting PC
  a_r2_epc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_trap_i |=> (mepc_o[XLEN-1:ALIGN_BITS] == $past(trap_pc_i[XLEN-1:ALIGN_BITS])));

endmodule

// File: rtl/trap_status_unit.sv
module trap_status_unit
  import trap_status_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic            mret_i,
  input  logic            csr_we_i,
  input  logic            csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [1:0]      priv_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] mepc_o
);

  localparam logic [XLEN-1:0] LEGAL_MASK =
    XLEN'((1 << BIT_UIE) | (1 << BIT_SIE) | (1 << BIT_MIE) | (1 << BIT_UPIE) |
          (1 << BIT_SPIE) | (1 << BIT_MPIE) | (1 << BIT_SPP) | (3 << BIT_MPP));

  priv_e priv;
  logic  do_trap, do_mret, wr_stat, wr_epc;

  tsu_event_arb i_arb (
    .rst_ni    (rst_ni),
    .clk_i     (clk_i),
    .trap_i    (trap_i),
    .mret_i    (mret_i),
    .csr_we_i  (csr_we_i),
    .csr_sel_i (csr_sel_i),
    .priv_i    (priv),
    .do_trap_o (do_trap),
    .do_mret_o (do_mret),
    .illegal_o (illegal_o),
    .wr_stat_o (wr_stat),
    .wr_epc_o  (wr_epc)
  );

  tsu_status_regs #(.XLEN(XLEN)) i_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .do_trap_i (do_trap),
    .do_mret_i (do_mret),
    .wr_stat_i (wr_stat),
    .wdata_i   (csr_wdata_i),
    .priv_o    (priv),
    .mstatus_o (mstatus_o)
  );

  tsu_epc_reg #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) i_epc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .do_trap_i (do_trap),
    .wr_epc_i  (wr_epc),
    .trap_pc_i (trap_pc_i),
    .wdata_i   (csr_wdata_i),
    .mepc_o    (mepc_o)
  );

  assign priv_o           = priv;
  assign redirect_valid_o = do_mret;
  assign redirect_pc_o    = mepc_o;

  // R5: illegal return leaves all state untouched
  a_r5_illegal_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> ($stable(priv_o) && $stable(mstatus_o) && $stable(mepc_o)));

  // R5: never both illegal and redirecting
  a_r5_no_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_o && redirect_valid_o));

  // R7: reserved status bits stay clear
  a_r7_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstatus_o & ~LEGAL_MASK) == '0);

  // R10: return address stays aligned
  a_r10_epc_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mepc_o[ALIGN_BITS-1:0] == '0);

endmodule

// File: tb/test_trap_status_unit.sv
module test_trap_status_unit;

  typedef struct packed {
    logic        trap;
    logic        mret;
    logic        we;
    logic        sel;
    logic [31:0] wdata;
    logic [31:0] pc;
    logic        ill;
    logic        rv;
    logic [31:0] rpc;
    logic [1:0]  priv;
    logic [31:0] ms;
    logic [31:0] epc;
  } vec_t;

  localparam int NV = 15;

  // trap mret we sel wdata pc | ill rv rpc | priv ms epc
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,32'hFFFF_FFFF,32'h0,     1'b0,1'b0,32'h0,         2'd3,32'h0000_19BB,32'h0},
    '{1'b0,1'b0,1'b1,1'b0,32'h0000_1000,32'h0,     1'b0,1'b0,32'h0,         2'd3,32'h0000_0000,32'h0},
    '{1'b0,1'b0,1'b1,1'b1,32'h8000_1237,32'h0,     1'b0,1'b0,32'h0,         2'd3,32'h0000_0000,32'h8000_1234},
    '{1'b0,1'b0,1'b1,1'b0,32'h0000_0808,32'h0,     1'b0,1'b0,32'h8000_1234, 2'd3,32'h0000_0808,32'h8000_1234},
    '{1'b0,1'b1,1'b0,1'b0,32'h0,        32'h0,     1'b0,1'b1,32'h8000_1234, 2'd1,32'h0000_0080,32'h8000_1234},
    '{1'b0,1'b1,1'b0,1'b0,32'h0,        32'h0,     1'b1,1'b0,32'h8000_1234, 2'd1,32'h0000_0080,32'h8000_1234},
    '{1'b0,1'b1,1'b1,1'b0,32'h0000_0008,32'h0,     1'b1,1'b0,32'h8000_1234, 2'd1,32'h0000_0080,32'h8000_1234},
    '{1'b1,1'b0,1'b0,1'b0,32'h0,        32'h4442,  1'b0,1'b0,32'h8000_1234, 2'd3,32'h0000_0800,32'h0000_4440},
    '{1'b0,1'b0,1'b1,1'b0,32'h0000_0888,32'h0,     1'b0,1'b0,32'h0000_4440, 2'd3,32'h0000_0888,32'h0000_4440},
    '{1'b1,1'b1,1'b0,1'b0,32'h0,        32'h0100,  1'b0,1'b0,32'h0000_4440, 2'd3,32'h0000_1880,32'h0000_0100},
    '{1'b0,1'b1,1'b0,1'b0,32'h0,        32'h0,     1'b0,1'b1,32'h0000_0100, 2'd3,32'h0000_0088,32'h0000_0100},
    '{1'b1,1'b0,1'b1,1'b1,32'hFFFF_FFF0,32'h2000,  1'b0,1'b0,32'h0000_0100, 2'd3,32'h0000_1880,32'h0000_2000},
    '{1'b0,1'b0,1'b1,1'b0,32'h0000_0644,32'h0,     1'b0,1'b0,32'h0000_2000, 2'd3,32'h0000_0000,32'h0000_2000},
    '{1'b0,1'b1,1'b0,1'b0,32'h0,        32'h0,     1'b0,1'b1,32'h0000_2000, 2'd0,32'h0000_0080,32'h0000_2000},
    '{1'b1,1'b0,1'b0,1'b0,32'h0,        32'h0013,  1'b0,1'b0,32'h0000_2000, 2'd3,32'h0000_0000,32'h0000_0010}
  };

  localparam string TAGS [NV] = '{
    "R6 R7 all fields", "R8 mpp legalize", "R10 epc write align", "R6 stage mpp",
    "R3 R4 R11 mret to S", "R5 mret from S", "R5 R9 mret with csr write",
    "R2 trap from S", "R6 reload", "R9 trap beats mret", "R3 R4 mret to M",
    "R9 trap beats csr", "R7 reserved write", "R3 R4 mret to U", "R2 R10 trap from U"
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trap_i = 1'b0;
  logic [31:0] trap_pc_i = '0;
  logic        mret_i = 1'b0;
  logic        csr_we_i = 1'b0;
  logic        csr_sel_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [1:0]  priv_o;
  logic        redirect_valid_o;
  logic [31:0] redirect_pc_o;
  logic        illegal_o;
  logic [31:0] mstatus_o;
  logic [31:0] mepc_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  trap_status_unit i_trap_status_unit (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .trap_i           (trap_i),
    .trap_pc_i        (trap_pc_i),
    .mret_i           (mret_i),
    .csr_we_i         (csr_we_i),
    .csr_sel_i        (csr_sel_i),
    .csr_wdata_i      (csr_wdata_i),
    .priv_o           (priv_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .illegal_o        (illegal_o),
    .mstatus_o        (mstatus_o),
    .mepc_o           (mepc_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input logic [1:0] p,
                             input logic [31:0] ms, input logic [31:0] epc);
    check(tag, "priv", {30'b0, priv_o}, {30'b0, p});
    check(tag, "mstatus", mstatus_o, ms);
    check(tag, "mepc", mepc_o, epc);
  endtask

  initial begin
    #7;
    check_state("R1 in reset", 2'd3, 32'h0, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check_state("R1 after release", 2'd3, 32'h0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      trap_i      = VECS[i].trap;
      mret_i      = VECS[i].mret;
      csr_we_i    = VECS[i].we;
      csr_sel_i   = VECS[i].sel;
      csr_wdata_i = VECS[i].wdata;
      trap_pc_i   = VECS[i].pc;
      #1;
      check(TAGS[i], "illegal", {31'b0, illegal_o}, {31'b0, VECS[i].ill});
      check(TAGS[i], "redirect_valid", {31'b0, redirect_valid_o}, {31'b0, VECS[i].rv});
      check(TAGS[i], "redirect_pc", redirect_pc_o, VECS[i].rpc);
      @(posedge clk_i); #1;
      check_state(TAGS[i], VECS[i].priv, VECS[i].ms, VECS[i].epc);
    end

    // R1: asynchronous reset mid-run restores the reset state
    @(negedge clk_i);
    trap_i = 1'b0; mret_i = 1'b0; csr_we_i = 1'b1; csr_sel_i = 1'b0;
    csr_wdata_i = 32'h0000_0888;
    @(posedge clk_i); #1;
    csr_we_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check_state("R1 async reset", 2'd3, 32'h0, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule